// File: doc/BRIEF.md
# Page-One Hardware Stack Unit

This block keeps an 8-bit stack pointer that selects a byte within one fixed 256-byte memory page based at 0x100. It takes byte and 16-bit push and pop requests on a small opcode port and drives a byte-wide synchronous memory (address, write data, write enable, read enable, read data). The memory is external and returns read data one clock after the read is issued. A 16-bit value takes two byte accesses in a fixed order, so that it sits in memory in little-endian form.

A push writes at the current pointer and then decrements it. A pop reads at the current pointer and then increments it. Because of this, a pop does not return the byte that the preceding push wrote. The pointer can be loaded from the request data and is always visible on an output. After reset the block can optionally zero the low 254 bytes of the page, one byte per clock, before it accepts any work.

Top module: `stack_page_unit`

## Requirements
- R1: After reset the pointer output reads 0xFF. With clearing enabled, busy is high from the first cycle after reset is released.
- R2: Every stack access (not clear writes) presents address 0x100 plus the current 8-bit pointer on the memory port, in the same cycle the request is accepted.
- R3: An 8-bit push (opcode 1) writes data bits 7:0 at the current pointer address and then decrements the pointer by one.
- R4: An 8-bit pop (opcode 2) reads the byte at the current pointer address and then increments the pointer. In the next cycle pop_valid is high and pop_data holds that byte zero-extended.
- R5: A 16-bit push (opcode 3) writes data bits 15:8 at the pointer, then bits 7:0 at the pointer minus one, and leaves the pointer two lower. Busy is high during the second beat only.
- R6: A 16-bit pop (opcode 4) takes the low byte from the pointer and the high byte from the pointer plus one, and leaves the pointer two higher. pop_valid with {high, low} appears in the cycle after the second beat.
- R7: The pointer wraps modulo 256 in both directions, with no flag: 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R8: A load (opcode 5) sets the pointer to data bits 7:0 in one cycle. Opcodes 0, 6 and 7 do nothing.
- R9: A request presented while busy is high is ignored. The pointer and memory are unaffected.
- R10: The reset clear writes zero to 0x100 through 0x1FD in ascending order, one byte per clock. Busy is high for exactly 254 cycles. Bytes 0x1FE and 0x1FF are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 3 | Request opcode (0 none, 1 push8, 2 pop8, 3 push16, 4 pop16, 5 load) |
| req_data | input | 16 | Push value or load value (bits 7:0) |
| busy | output | 1 | High while a second beat or the reset clear is in progress |
| sp_out | output | 8 | Current stack pointer |
| pop_valid | output | 1 | Pop result valid this cycle |
| pop_data | output | 16 | Pop result |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |

## Verification
The delivery of a 16-bit pop result falls in the same cycle in which the next request is accepted. In the vector walk each new operation is driven right after a 16-bit pop's second beat, and the merged result is sampled before a following push can overwrite the held low byte. A second collision is a request driven into the busy second beat of a 16-bit push, or during the reset clear. It is judged by the pointer value and by later pops, which show that nothing moved.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_PUSH8  = 3'd1,
      OP_POP8   = 3'd2,
      OP_PUSH16 = 3'd3,
      OP_POP16  = 3'd4,
      OP_LOAD   = 3'd5
   } stk_op_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PUSH_LO = 2'd1,
      ST_POP_HI  = 2'd2
   } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int PTR_W = 8,
   parameter logic [PTR_W-1:0] RESET_PTR = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   output logic [PTR_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n)    ptr <= RESET_PTR;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= ptr + 1'b1;
      else if (dec)  ptr <= ptr - 1'b1;
   end

   // R7
   ptr_inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && !dec) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
   // R3
   ptr_dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !inc) |=> (ptr == PTR_W'($past(ptr) - 1'b1)));
   // R8
   ptr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec));
endmodule

// File: rtl/stk_clear.sv
module stk_clear #(
   parameter int PTR_W       = 8,
   parameter int CLEAR_BYTES = 254,
   parameter bit ENABLE      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             clearing,
   output logic [PTR_W-1:0] idx
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(CLEAR_BYTES - 1);

   if (CLEAR_BYTES < 1 || CLEAR_BYTES > (1 << PTR_W)) begin : g_bad_count
      $error("stk_clear: CLEAR_BYTES out of range");
   end

   if (ENABLE) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            clearing <= 1'b1;
            idx      <= '0;
         end else if (clearing) begin
            idx <= idx + 1'b1;
            if (idx == LAST) clearing <= 1'b0;
         end
      end

      // R10
      clear_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clearing && $past(clearing) && $past(rst_n)) |-> (idx == PTR_W'($past(idx) + 1'b1)));
   end else begin : g_no_clear
      assign clearing = 1'b0;
      assign idx      = '0;
   end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PTR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clearing,
   input  logic [2:0]          req_op,
   input  logic [2*DATA_W-1:0] req_data,
   input  logic [DATA_W-1:0]   rd_byte,
   output logic                seq_busy,
   output logic                wr_en,
   output logic                rd_en,
   output logic [DATA_W-1:0]   wr_byte,
   output logic                ptr_inc,
   output logic                ptr_dec,
   output logic                ptr_load,
   output logic [PTR_W-1:0]    ptr_val,
   output logic                res_valid,
   output logic [2*DATA_W-1:0] res_data
);
   stk_state_e          state;
   logic [DATA_W-1:0]   lo_q;
   logic                pv8_q, pv16_q;
   logic                accept;
   logic                is_push8, is_pop8, is_push16, is_pop16, is_load;

   assign accept    = !clearing && (state == ST_IDLE);
   assign is_push8  = accept && (req_op == OP_PUSH8);
   assign is_pop8   = accept && (req_op == OP_POP8);
   assign is_push16 = accept && (req_op == OP_PUSH16);
   assign is_pop16  = accept && (req_op == OP_POP16);
   assign is_load   = accept && (req_op == OP_LOAD);

   assign seq_busy = (state != ST_IDLE);
   assign wr_en    = is_push8 || is_push16 || (state == ST_PUSH_LO);
   assign rd_en    = is_pop8 || is_pop16 || (state == ST_POP_HI);
   assign ptr_inc  = rd_en;
   assign ptr_dec  = wr_en;
   assign ptr_load = is_load;
   assign ptr_val  = req_data[PTR_W-1:0];

   always_comb begin
      if (state == ST_PUSH_LO) wr_byte = lo_q;
      else if (is_push16)      wr_byte = req_data[2*DATA_W-1:DATA_W];
      else                     wr_byte = req_data[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         lo_q   <= '0;
         pv8_q  <= 1'b0;
         pv16_q <= 1'b0;
      end else begin
         pv8_q  <= is_pop8;
         pv16_q <= (state == ST_POP_HI);
         case (state)
            ST_IDLE: begin
               if (is_push16) begin
                  state <= ST_PUSH_LO;
                  lo_q  <= req_data[DATA_W-1:0];
               end else if (is_pop16) begin
                  state <= ST_POP_HI;
               end
            end
            ST_POP_HI: begin
               lo_q  <= rd_byte;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign res_valid = pv8_q || pv16_q;
   assign res_data  = pv16_q ? {rd_byte, lo_q} : {{DATA_W{1'b0}}, rd_byte};

   // R5
   second_beat_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |=> !seq_busy);
   // R4
   pop_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(rd_en));
   // R9
   busy_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy || clearing) |-> !ptr_load);
endmodule

// File: rtl/stack_page_unit.sv
module stack_page_unit
   import stk_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int PTR_W          = 8,
   parameter int ADDR_W         = 16,
   parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h0100,
   parameter logic [PTR_W-1:0]  RESET_PTR = 8'hFF,
   parameter int CLEAR_BYTES    = 254,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          req_op,
   input  logic [2*DATA_W-1:0] req_data,
   output logic                busy,
   output logic [PTR_W-1:0]    sp_out,
   output logic                pop_valid,
   output logic [2*DATA_W-1:0] pop_data,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_we,
   output logic                mem_re,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata
);
   localparam int WORD_W = 2 * DATA_W;

   if (PTR_W >= ADDR_W || PTR_W > WORD_W) begin : g_bad_width
      $error("stack_page_unit: pointer wider than address or data");
   end

   logic             clearing, seq_busy;
   logic [PTR_W-1:0] clr_idx, ptr_val;
   logic             ptr_inc, ptr_dec, ptr_load;
   logic             s_we, s_re;
   logic [DATA_W-1:0] s_wbyte;

   stk_clear #(.PTR_W(PTR_W), .CLEAR_BYTES(CLEAR_BYTES), .ENABLE(CLEAR_ON_RESET)) u_clear (
      .clk(clk), .rst_n(rst_n), .clearing(clearing), .idx(clr_idx));

   stk_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .clearing(clearing), .req_op(req_op),
      .req_data(req_data), .rd_byte(mem_rdata), .seq_busy(seq_busy),
      .wr_en(s_we), .rd_en(s_re), .wr_byte(s_wbyte), .ptr_inc(ptr_inc),
      .ptr_dec(ptr_dec), .ptr_load(ptr_load), .ptr_val(ptr_val),
      .res_valid(pop_valid), .res_data(pop_data));

   stk_ptr #(.PTR_W(PTR_W), .RESET_PTR(RESET_PTR)) u_ptr (
      .clk(clk), .rst_n(rst_n), .inc(ptr_inc), .dec(ptr_dec),
      .load(ptr_load), .load_val(ptr_val), .ptr(sp_out));

   assign busy      = clearing || seq_busy;
   assign mem_we    = clearing || s_we;
   assign mem_re    = !clearing && s_re;
   assign mem_wdata = clearing ? '0 : s_wbyte;
   assign mem_addr  = PAGE_BASE + ADDR_W'(clearing ? clr_idx : sp_out);

   // R2
   page_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_we || s_re) && !clearing) |-> (mem_addr == PAGE_BASE + ADDR_W'(sp_out)));
   // R10
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clearing |-> (mem_we && mem_wdata == '0 && !mem_re));
   // R9
   clear_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clearing && $past(clearing) && $past(rst_n)) |-> $stable(sp_out));
endmodule

// File: tb/tb_stack_page_unit.sv
`timescale 1ns/1ps
module tb_stack_page_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic [15:0] req_data = 16'h0;
   logic        busy, pop_valid, mem_we, mem_re;
   logic [7:0]  sp_out, mem_wdata, mem_rdata;
   logic [15:0] pop_data, mem_addr;
   logic [7:0]  page [256];
   logic        seeded = 1'b0;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   stack_page_unit dut (
      .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_data(req_data),
      .busy(busy), .sp_out(sp_out), .pop_valid(pop_valid), .pop_data(pop_data),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   // byte-wide synchronous page memory, seeded with 0xA5
   always @(posedge clk) begin
      if (!seeded) begin
         for (int i = 0; i < 256; i++) page[i] <= 8'hA5;
         seeded <= 1'b1;
      end else if (mem_we && mem_addr[15:8] == 8'h01) begin
         page[mem_addr[7:0]] <= mem_wdata;
      end
      mem_rdata <= page[mem_addr[7:0]];
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive an op at a negedge and return at the negedge after it completes
   task automatic run_op(input logic [2:0] op, input logic [15:0] d);
      req_op = op; req_data = d;
      @(posedge clk);
      if (op == 3'd3 || op == 3'd4) begin
         @(negedge clk); req_op = 3'd0;
         @(posedge clk);
      end
      @(negedge clk); req_op = 3'd0;
   endtask

   // {op, data, expected sp, expected pop_valid, expected pop_data}
   localparam logic [43:0] VEC [15] = '{
      {3'd1, 16'h0011, 8'hFE, 1'b0, 16'h0000},
      {3'd3, 16'hBEEF, 8'hFC, 1'b0, 16'h0000},
      {3'd4, 16'h0000, 8'hFE, 1'b1, 16'hEF00},
      {3'd2, 16'h0000, 8'hFF, 1'b1, 16'h00BE},
      {3'd2, 16'h0000, 8'h00, 1'b1, 16'h0011},
      {3'd2, 16'h0000, 8'h01, 1'b1, 16'h0000},
      {3'd5, 16'h0000, 8'h00, 1'b0, 16'h0000},
      {3'd1, 16'h005A, 8'hFF, 1'b0, 16'h0000},
      {3'd3, 16'h1234, 8'hFD, 1'b0, 16'h0000},
      {3'd5, 16'h00FE, 8'hFE, 1'b0, 16'h0000},
      {3'd4, 16'h0000, 8'h00, 1'b1, 16'h1234},
      {3'd2, 16'h0000, 8'h01, 1'b1, 16'h005A},
      {3'd3, 16'hA1B2, 8'hFF, 1'b0, 16'h0000},
      {3'd5, 16'h0000, 8'h00, 1'b0, 16'h0000},
      {3'd4, 16'h0000, 8'h02, 1'b1, 16'hA1B2}
   };

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int busy_cycles;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R10 first clear write
      chk("R1 sp after reset", {8'h0, sp_out}, 16'h00FF);
      chk("R1 busy after reset", {15'h0, busy}, 16'h1);
      chk("R10 clear first addr", mem_addr, 16'h0100);
      chk("R10 clear write zero", {7'h0, mem_we, mem_wdata}, 16'h0100);
      busy_cycles = 0;
      while (busy && busy_cycles < 1000) begin
         busy_cycles++;
         if (busy_cycles == 10) begin req_op = 3'd5; req_data = 16'h0033; end
         if (busy_cycles == 11) req_op = 3'd0;
         @(negedge clk);
      end
      req_op = 3'd0;
      chk("R10 clear length", 16'(busy_cycles), 16'd254);
      chk("R9 load ignored during clear", {8'h0, sp_out}, 16'h00FF);

      // R10 boundary: 0x1FD cleared, 0x1FE/0x1FF untouched
      run_op(3'd5, 16'h00FD);
      run_op(3'd2, 16'h0);
      chk("R10 last cleared byte", pop_data, 16'h0000);
      run_op(3'd2, 16'h0);
      chk("R10 byte 1FE untouched", pop_data, 16'h00A5);
      run_op(3'd2, 16'h0);
      chk("R10 byte 1FF untouched", pop_data, 16'h00A5);
      chk("R7 pop wraps to 00", {8'h0, sp_out}, 16'h0000);
      run_op(3'd5, 16'h00FF);
      chk("R8 load value", {8'h0, sp_out}, 16'h00FF);

      // vector walk: R3 R4 R5 R6 R7 R8
      for (int v = 0; v < 15; v++) begin
         run_op(VEC[v][43:41], VEC[v][40:25]);
         chk($sformatf("R3-6 vec%0d sp", v), {8'h0, sp_out}, {8'h0, VEC[v][24:17]});
         chk($sformatf("R4 R6 vec%0d pop_valid", v), {15'h0, pop_valid}, {15'h0, VEC[v][16]});
         if (VEC[v][16])
            chk($sformatf("R4 R6 vec%0d pop_data", v), pop_data, VEC[v][15:0]);
      end

      // R9: request in second beat of a 16-bit push is ignored
      req_op = 3'd3; req_data = 16'hCAFE;
      @(posedge clk); @(negedge clk);
      chk("R5 busy in second beat", {15'h0, busy}, 16'h1);
      req_op = 3'd1; req_data = 16'h0077;
      @(posedge clk); @(negedge clk);
      req_op = 3'd0;
      chk("R9 push ignored while busy", {8'h0, sp_out}, 16'h0000);
      chk("R5 busy drops", {15'h0, busy}, 16'h0);
      run_op(3'd5, 16'h0001);
      run_op(3'd4, 16'h0);
      chk("R9 R6 stored word intact", pop_data, 16'hCAFE);

      // R2 address on the port, R8 idle opcodes
      run_op(3'd5, 16'h0040);
      req_op = 3'd1; req_data = 16'h0099;
      #1;
      chk("R2 push address", mem_addr, 16'h0140);
      chk("R3 push write", {7'h0, mem_we, mem_wdata}, 16'h0199);
      @(posedge clk); @(negedge clk);
      req_op = 3'd2;
      #1;
      chk("R2 pop address", mem_addr, 16'h013F);
      chk("R4 pop read enable", {15'h0, mem_re}, 16'h1);
      @(posedge clk); @(negedge clk);
      req_op = 3'd7;
      @(posedge clk); @(negedge clk);
      req_op = 3'd6;
      @(posedge clk); @(negedge clk);
      req_op = 3'd0;
      chk("R8 idle opcodes keep sp", {8'h0, sp_out}, 16'h0040);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule